// File: doc/BRIEF.md
# Configurable Burst Address Sequencer

This block is the address front end of a 16K-word by 16-bit read-only memory. It accepts an external 14-bit word address and turns it into the address the memory array sees. It can hold that address in one of two ways. In the clocked style, an edge-triggered register captures it. In the level style, a transparent latch tracks the external bus while its enable is low and freezes it when the enable rises.

Once an address is held, a burst can start. At each rising clock edge where the active-low advance input is sampled low, a step counter moves on. The low address bits then follow one of four patterns: an XOR-interleaved processor order over two bits, or a linear count that wraps inside a 2-, 4- or 8-bit low field. The address bits above the selected field are never touched by a burst. All configuration arrives as static inputs. The memory array, the output drivers and the programming logic sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: With cfg_latched = 0, one or more clock edges with rst high leave word_addr at 0 once rst is released.
- R2: With cfg_latched = 0, a rising edge with adv_n high loads ext_addr, and word_addr shows it after that edge. Later changes of ext_addr do not reach word_addr until the next load edge.
- R3: With cfg_latched = 1 and le_n low, word_addr equals ext_addr at once, with no clock edge needed.
- R4: With cfg_latched = 1, once le_n has risen, word_addr keeps the last value passed through and ignores ext_addr, while adv_n stays high.
- R5: With cfg_latched = 1, a burst step happens only at a rising edge where le_n is high and adv_n is low. An edge with adv_n high leaves word_addr unchanged.
- R6: With cfg_burst_en = 0, the address never advances. In the clocked style, an edge with adv_n low holds word_addr unchanged.
- R7: With cfg_kind = 2'b00, after n steps bits [1:0] of word_addr equal the start bits [1:0] XOR (n mod 4), and bits [13:2] are held.
- R8: With cfg_kind = 2'b01, 2'b10 or 2'b11, after n steps the low 2, 4 or 8 bits equal (start field + n) modulo 4, 16 or 256, and all higher bits are held.
- R9: A load resets the step count to zero. In the clocked style this is an edge with adv_n high; in the level style it is an edge with le_n low. The next step after a load yields the loaded address advanced by exactly one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_latched | input | 1 | 0 selects the edge register, 1 selects the transparent latch |
| cfg_burst_en | input | 1 | 1 allows bursts, 0 freezes the step count |
| cfg_kind | input | 2 | Burst pattern: 00 XOR over 2 bits, 01 linear over 2 bits, 10 linear over 4 bits, 11 linear over 8 bits |
| le_n | input | 1 | Active-low latch enable (latch transparent while low) |
| adv_n | input | 1 | Active-low burst advance |
| ext_addr | input | 14 | External word address |
| word_addr | output | 14 | Word address driven to the memory array |

## Verification
Two internal faults matter most: a step count that is stale or off by one, and a held address that has been overwritten. The first shows on word_addr right after the next burst edge. Either the low field lands on the wrong value, or a carry spills into the bits above the field; this is why the start addresses sit at field boundaries (all-ones fields and full wraps). The second shows as soon as ext_addr moves while the block should be holding. The bench changes ext_addr after every close or load and compares word_addr within the same cycle, before the next edge can hide the fault.

// File: rtl/bas_pkg.sv
package bas_pkg;

    parameter int ADDR_W = 14;
    parameter int STEP_W = 8;

    typedef enum logic [1:0] {
        KIND_XOR2 = 2'b00,
        KIND_LIN2 = 2'b01,
        KIND_LIN4 = 2'b10,
        KIND_LIN8 = 2'b11
    } burst_kind_e;

    typedef struct packed {
        logic        latched;
        logic        burst_en;
        burst_kind_e kind;
    } bas_cfg_t;

    typedef struct packed {
        logic load_reg;
        logic clear;
        logic advance;
        logic pass_open;
    } step_ctl_t;

    // width of the low field a burst kind may modify
    function automatic int field_width(burst_kind_e k);
        case (k)
            KIND_LIN4: return 4;
            KIND_LIN8: return 8;
            default:   return 2;
        endcase
    endfunction

    // derive the control strobes for one cycle from config and pins
    function automatic step_ctl_t decode_ctl(bas_cfg_t c, logic le_n, logic adv_n);
        step_ctl_t r;
        r = '0;
        if (c.latched) begin
            r.pass_open = !le_n;
            r.clear     = !le_n;
            r.advance   = le_n && !adv_n && c.burst_en;
        end else begin
            r.load_reg  = adv_n;
            r.clear     = adv_n;
            r.advance   = !adv_n && c.burst_en;
        end
        return r;
    endfunction

endpackage

// File: rtl/bas_capture.sv
module bas_capture
    import bas_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          use_latch,
    input  logic          load_reg,
    input  logic          le_n,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] base_addr
);

    logic [AW-1:0] reg_q;
    logic [AW-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst)
            reg_q <= '0;
        else if (load_reg)
            reg_q <= ext_addr;
    end

    always_latch begin
        if (!le_n)
            latch_q <= ext_addr;
    end

    assign base_addr = use_latch ? latch_q : reg_q;

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!use_latch && load_reg) |=> (reg_q == $past(ext_addr)));

endmodule

// File: rtl/bas_step_ctr.sv
module bas_step_ctr
    import bas_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          advance,
    output logic [SW-1:0] step
);

    always_ff @(posedge clk) begin
        if (rst)
            step <= '0;
        else if (clear)
            step <= '0;
        else if (advance)
            step <= step + 1'b1;
    end

    // R9
    step_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (step == '0));

    // R5
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !advance) |=> $stable(step));

endmodule

// File: rtl/bas_compose.sv
module bas_compose
    import bas_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STEP_W
) (
    input  logic          burst_en,
    input  burst_kind_e   kind,
    input  logic [AW-1:0] base_addr,
    input  logic [SW-1:0] step,
    output logic [AW-1:0] word_addr
);

    localparam int HI_W = AW - SW;

    logic [SW-1:0] sum_low;
    logic [SW-1:0] mix_low;
    logic [SW-1:0] field_sel;
    int            fw;

    always_comb begin
        fw      = field_width(kind);
        sum_low = base_addr[SW-1:0] + step;
        mix_low = (kind == KIND_XOR2) ? (base_addr[SW-1:0] ^ step) : sum_low;
    end

    for (genvar i = 0; i < SW; i++) begin : g_bit
        assign field_sel[i] = burst_en && (i < fw);
        assign word_addr[i] = field_sel[i] ? mix_low[i] : base_addr[i];
    end

    if (HI_W > 0) begin : g_high
        assign word_addr[AW-1:SW] = base_addr[AW-1:SW];
    end

    // R8
    always_comb begin
        if (!$isunknown(base_addr) && !$isunknown(step))
            upper_hold_chk: assert (word_addr[AW-1:2] ==
                ((kind == KIND_XOR2 || kind == KIND_LIN2 || !burst_en)
                    ? base_addr[AW-1:2] : word_addr[AW-1:2]));
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_latched,
    input  logic              cfg_burst_en,
    input  logic [1:0]        cfg_kind,
    input  logic              le_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] word_addr
);

    bas_cfg_t          cfg;
    step_ctl_t         ctl;
    logic [ADDR_W-1:0] base_addr;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_eff;

    always_comb begin
        cfg.latched  = cfg_latched;
        cfg.burst_en = cfg_burst_en;
        cfg.kind     = burst_kind_e'(cfg_kind);
        ctl          = decode_ctl(cfg, le_n, adv_n);
        step_eff     = ctl.pass_open ? '0 : step_q;
    end

    bas_capture #(.AW(ADDR_W)) capture_i (
        .clk       (clk),
        .rst       (rst),
        .use_latch (cfg.latched),
        .load_reg  (ctl.load_reg),
        .le_n      (le_n),
        .ext_addr  (ext_addr),
        .base_addr (base_addr)
    );

    bas_step_ctr #(.SW(STEP_W)) step_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctl.clear),
        .advance (ctl.advance),
        .step    (step_q)
    );

    bas_compose #(.AW(ADDR_W), .SW(STEP_W)) compose_i (
        .burst_en  (cfg.burst_en),
        .kind      (cfg.kind),
        .base_addr (base_addr),
        .step      (step_eff),
        .word_addr (word_addr)
    );

    // R6
    no_burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_latched && !cfg_burst_en && !adv_n)
        |=> ($stable(word_addr) || !$stable({cfg_latched, cfg_burst_en, cfg_kind})));

    // R4
    latch_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_latched && le_n && adv_n)
        |=> (!le_n || !adv_n || $stable(word_addr)
             || !$stable({cfg_latched, cfg_burst_en, cfg_kind})));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    typedef struct packed {
        logic [1:0]  kind;
        logic [13:0] start;
        logic [8:0]  steps;
        logic [13:0] expect_addr;
    } vec_t;

    // R7 rows use kind 00, R8 rows use kinds 01/10/11
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 14'h0001, 9'd1,   14'h0000},
        '{2'b00, 14'h0001, 9'd2,   14'h0003},
        '{2'b00, 14'h0001, 9'd3,   14'h0002},
        '{2'b00, 14'h3FFE, 9'd3,   14'h3FFD},
        '{2'b00, 14'h0002, 9'd4,   14'h0002},
        '{2'b01, 14'h0003, 9'd1,   14'h0000},
        '{2'b01, 14'h0003, 9'd2,   14'h0001},
        '{2'b10, 14'h00FE, 9'd2,   14'h00F0},
        '{2'b10, 14'h2AAA, 9'd16,  14'h2AAA},
        '{2'b11, 14'h12FF, 9'd1,   14'h1200},
        '{2'b11, 14'h12FF, 9'd5,   14'h1204},
        '{2'b11, 14'h3F80, 9'd128, 14'h3F00}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_latched;
    logic        cfg_burst_en;
    logic [1:0]  cfg_kind;
    logic        le_n;
    logic        adv_n;
    logic [13:0] ext_addr;
    logic [13:0] word_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_latched  (cfg_latched),
        .cfg_burst_en (cfg_burst_en),
        .cfg_kind     (cfg_kind),
        .le_n         (le_n),
        .adv_n        (adv_n),
        .ext_addr     (ext_addr),
        .word_addr    (word_addr)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [13:0] expv);
        checks++;
        if (word_addr !== expv) begin
            errors++;
            $display("FAIL %s: word_addr=%h expected=%h", req, word_addr, expv);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_latched = 1'b0; cfg_burst_en = 1'b1; cfg_kind = 2'b00;
        le_n = 1'b1; adv_n = 1'b1; ext_addr = 14'h2345;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        check("R1", 14'h0000);

        // table walk, clocked style
        for (int v = 0; v < NVEC; v++) begin
            cfg_kind = VECS[v].kind;
            ext_addr = VECS[v].start;
            adv_n    = 1'b1;
            tick();
            adv_n = 1'b0;
            for (int s = 0; s < int'(VECS[v].steps); s++) tick();
            check(VECS[v].kind == 2'b00 ? "R7" : "R8", VECS[v].expect_addr);
            adv_n = 1'b1;
        end

        // R2: load, then hold with bursts disabled
        cfg_kind = 2'b10; ext_addr = 14'h1111; adv_n = 1'b1;
        tick();
        check("R2", 14'h1111);
        cfg_burst_en = 1'b0; adv_n = 1'b0; ext_addr = 14'h2222;
        #1 check("R2", 14'h1111);
        tick(); tick();
        check("R6", 14'h1111);
        adv_n = 1'b1;
        tick();
        check("R2", 14'h2222);
        cfg_burst_en = 1'b1;

        // R9: reload mid-burst restarts the step count
        ext_addr = 14'h0010; tick();
        adv_n = 1'b0; tick(); tick(); tick();
        check("R8", 14'h0013);
        adv_n = 1'b1; ext_addr = 14'h0020; tick();
        check("R9", 14'h0020);
        adv_n = 1'b0; tick();
        check("R9", 14'h0021);
        adv_n = 1'b1;

        // level style
        cfg_latched = 1'b1; cfg_kind = 2'b01; le_n = 1'b0; ext_addr = 14'h1234;
        #1 check("R3", 14'h1234);
        ext_addr = 14'h0567;
        #1 check("R3", 14'h0567);
        tick();
        check("R3", 14'h0567);
        le_n = 1'b1;
        #1 ext_addr = 14'h3FFF;
        #1 check("R4", 14'h0567);
        tick();
        check("R4", 14'h0567);
        adv_n = 1'b0; tick();
        check("R5", 14'h0564);
        adv_n = 1'b1; tick();
        check("R5", 14'h0564);
        le_n = 1'b0; ext_addr = 14'h0A01;
        #1 check("R3", 14'h0A01);
        tick();
        le_n = 1'b1; adv_n = 1'b0; tick();
        check("R9", 14'h0A02);
        adv_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule